// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves the branch outcome for the relative-jump instruction class of a 16-bit processor. Each cycle that a jump is presented, it takes the address of the jump instruction, a 3-bit condition selector, a 10-bit signed offset and the four arithmetic status flags (carry, zero, negative, overflow). One clock later it reports whether the jump is taken and which program counter comes next.

The offset counts 16-bit words, so a taken jump lands at the address of the instruction plus two plus twice the sign-extended offset. A jump that is not taken falls through to the address of the instruction plus two. Both sums wrap modulo the program counter width. Fetching from the new address and flushing the pipeline are left to the surrounding core. Between requests the outputs keep the last result.

Top module: `jump_unit`

## Requirements
- R1: While rstN is low, and after it is released until the first request, outValid and taken are 0 and nextPc is 0.
- R2: Each cycle with inValid high produces exactly one cycle with outValid high, on the following clock edge. outValid is low in every other cycle.
- R3: Selector value 0 (not zero) is taken exactly when flagZ is 0.
- R4: Selector value 1 (zero) is taken exactly when flagZ is 1.
- R5: Selector value 2 (no carry) is taken exactly when flagC is 0. Selector value 3 (carry) is taken exactly when flagC is 1.
- R6: Selector value 4 (negative) is taken exactly when flagN is 1.
- R7: Selector value 5 (signed greater-or-equal) is taken exactly when flagN equals flagV.
- R8: Selector value 6 (signed less-than) is taken exactly when flagN differs from flagV.
- R9: Selector value 7 is always taken, whatever the flags are.
- R10: When taken, nextPc equals pc + 2 + 2 * offset. The offset is a two's-complement value in bits 9:0, and the sum wraps modulo 2^16.
- R11: When not taken, nextPc equals pc + 2, modulo 2^16.
- R12: In a cycle without a request, taken and nextPc keep their values from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A jump is presented this cycle |
| pc | input | 16 | Address of the jump instruction |
| cond | input | 3 | Condition selector, 0 to 7 |
| offset | input | 10 | Signed word offset |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| outValid | output | 1 | Result valid, one cycle after the request |
| taken | output | 1 | The jump is taken |
| nextPc | output | 16 | Program counter that follows the jump |

## Verification
Every selector is driven with all sixteen flag combinations. This shows that each condition reads only its own flags, and it separates the signed pair (N equal to V, N differing from V) from the plain negative test. Offsets at both limits (+511 and -512), a zero offset, and program counters near the top and bottom of the address space show whether the target is sign-extended, scaled by two and wrapped. The fall-through sum is compared separately from the target. Requests arrive both back to back and with gaps, so the bench can tell the one-cycle result pulse apart from outputs that are held between requests.

// File: rtl/jump_unit_pkg.sv
package jump_unit_pkg;

  typedef enum logic [2:0] {
    CC_NOT_ZERO = 3'd0,
    CC_ZERO     = 3'd1,
    CC_NO_CARRY = 3'd2,
    CC_CARRY    = 3'd3,
    CC_NEG      = 3'd4,
    CC_GE       = 3'd5,
    CC_LT       = 3'd6,
    CC_ALWAYS   = 3'd7
  } jmpCond_e;

  localparam int unsigned COND_COUNT = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic take;
  } jmpStrobe_t;

endpackage

// File: rtl/jump_unit_ctrl.sv
module jump_unit_ctrl
  import jump_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] cond,
  input  logic       flagC,
  input  logic       flagZ,
  input  logic       flagN,
  input  logic       flagV,
  output jmpStrobe_t strobe,
  output logic       outValid,
  output logic       taken
);

  logic [COND_COUNT-1:0] condHit;
  logic                  signedLess;
  logic                  takeNow;

  assign signedLess = flagN ^ flagV;

  // one hit bit per selector value
  always_comb begin
    condHit              = '0;
    condHit[CC_NOT_ZERO] = ~flagZ;
    condHit[CC_ZERO]     = flagZ;
    condHit[CC_NO_CARRY] = ~flagC;
    condHit[CC_CARRY]    = flagC;
    condHit[CC_NEG]      = flagN;
    condHit[CC_GE]       = ~signedLess;
    condHit[CC_LT]       = signedLess;
    condHit[CC_ALWAYS]   = 1'b1;
  end

  assign takeNow     = condHit[cond];
  assign strobe.load = inValid;
  assign strobe.take = inValid & takeNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) taken <= takeNow;
    end
  end

endmodule

// File: rtl/jump_unit_dp.sv
module jump_unit_dp
  import jump_unit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  jmpStrobe_t       strobe,
  output logic [PC_W-1:0]  nextPc
);

  localparam int unsigned EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] dispBytes;
  logic [PC_W-1:0] targetPc;

  generate
    if (EXT_W > 0) begin : g_ext
      logic [PC_W-1:0] offWide;
      assign offWide   = {{EXT_W{offset[OFF_W-1]}}, offset};
      assign dispBytes = offWide << 1;
    end else begin : g_noext
      assign dispBytes = PC_W'(offset) << 1;
    end
  endgenerate

  assign seqPc    = pc + INSN_BYTES;
  assign targetPc = seqPc + dispBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc <= '0;
    end else if (strobe.load) begin
      nextPc <= strobe.take ? targetPc : seqPc;
    end
  end

endmodule

// File: rtl/jump_unit.sv
module jump_unit
  import jump_unit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PC_W-1:0]  pc,
  input  logic [2:0]       cond,
  input  logic [OFF_W-1:0] offset,
  input  logic             flagC,
  input  logic             flagZ,
  input  logic             flagN,
  input  logic             flagV,
  output logic             outValid,
  output logic             taken,
  output logic [PC_W-1:0]  nextPc
);

  jmpStrobe_t strobe;

  jump_unit_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .cond     (cond),
    .flagC    (flagC),
    .flagZ    (flagZ),
    .flagN    (flagN),
    .flagV    (flagV),
    .strobe   (strobe),
    .outValid (outValid),
    .taken    (taken)
  );

  jump_unit_dp #(.PC_W(PC_W), .OFF_W(OFF_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .pc     (pc),
    .offset (offset),
    .strobe (strobe),
    .nextPc (nextPc)
  );

endmodule

// File: rtl/jump_unit_chk.sv
module jump_unit_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [PC_W-1:0]  pc,
  input logic [2:0]       cond,
  input logic [OFF_W-1:0] offset,
  input logic             flagC,
  input logic             flagZ,
  input logic             flagN,
  input logic             flagV,
  input logic             outValid,
  input logic             taken,
  input logic [PC_W-1:0]  nextPc
);

  logic [PC_W-1:0] expSeq;
  logic [PC_W-1:0] expTgt;
  assign expSeq = pc + PC_W'(2);
  assign expTgt = expSeq + PC_W'($signed(offset) * 2);

  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !outValid && !taken && nextPc == '0);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r4_zero_taken: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cond == 3'd1 |=> taken == $past(flagZ));

  a_r7_ge_taken: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cond == 3'd5 |=> taken == ($past(flagN) == $past(flagV)));

  a_r8_lt_taken: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cond == 3'd6 |=> taken == ($past(flagN) != $past(flagV)));

  a_r9_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cond == 3'd7 |=> taken);

  a_r10_target: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cond == 3'd7 |=> nextPc == $past(expTgt));

  a_r11_fallthrough: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (taken || nextPc == $past(expSeq)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !inValid |=> $stable(nextPc) && $stable(taken));

endmodule

bind jump_unit jump_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) chk_i (.*);

// File: tb/jump_unit_tb_top.sv
`timescale 1ns/1ps
module jump_unit_tb_top;

  localparam int unsigned PC_W  = 16;
  localparam int unsigned OFF_W = 10;

  typedef struct {
    logic            tk;
    logic [PC_W-1:0] npc;
    string           ctag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [PC_W-1:0]  pc = '0;
  logic [2:0]       cond = '0;
  logic [OFF_W-1:0] offset = '0;
  logic             flagC = 1'b0, flagZ = 1'b0, flagN = 1'b0, flagV = 1'b0;
  logic             outValid, taken;
  logic [PC_W-1:0]  nextPc;

  int testsRun = 0;
  int testsFailed = 0;
  int pushed = 0;
  int popped = 0;
  bit monOn = 1'b0;
  expItem_t sbQ[$];

  always #4 clk = ~clk;

  jump_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pc(pc), .cond(cond),
    .offset(offset), .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV),
    .outValid(outValid), .taken(taken), .nextPc(nextPc)
  );

  function automatic void check(bit ok, string tag, string what, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic logic refTaken(logic [2:0] c, logic fc, logic fz, logic fn, logic fv);
    case (c)
      3'd0: return !fz;
      3'd1: return fz;
      3'd2: return !fc;
      3'd3: return fc;
      3'd4: return fn;
      3'd5: return fn == fv;
      3'd6: return fn != fv;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string condTag(logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic sendJump(logic [PC_W-1:0] p, logic [2:0] c, logic [OFF_W-1:0] o, logic [3:0] f);
    expItem_t e;
    logic [PC_W-1:0] sx;
    @(negedge clk);
    pc = p; cond = c; offset = o;
    {flagC, flagZ, flagN, flagV} = f;
    inValid = 1'b1;
    sx = {{(PC_W-OFF_W){o[OFF_W-1]}}, o};
    e.tk = refTaken(c, f[3], f[2], f[1], f[0]);
    e.npc = e.tk ? (p + 16'd2 + (sx << 1)) : (p + 16'd2);
    e.ctag = condTag(c);
    sbQ.push_back(e);
    pushed++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: compare results as they appear
  always @(negedge clk) begin
    if (monOn && outValid) begin
      expItem_t e;
      if (sbQ.size() == 0) begin
        check(1'b0, "R2", "unexpected outValid", 1, 0);
      end else begin
        e = sbQ.pop_front();
        popped++;
        check(taken === e.tk, e.ctag, "taken", taken, e.tk);
        check(nextPc === e.npc, e.tk ? "R10" : "R11", "nextPc", nextPc, e.npc);
      end
    end
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] heldPc;
    logic            heldTk;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid in reset", outValid, 0);
    check(taken === 1'b0, "R1", "taken in reset", taken, 0);
    check(nextPc === '0, "R1", "nextPc in reset", nextPc, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && nextPc === '0, "R1", "state after release", nextPc, 0);
    monOn = 1'b1;

    // every selector against every flag pattern, back to back
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        sendJump(16'h4000 + 16'(c * 64 + f * 4), 3'(c), 10'(f * 37 - 200), 4'(f));
    idle(2);

    // offset limits and wrap of the address
    sendJump(16'h1000, 3'd7, 10'h1FF, 4'h0);   // +511 -> 0x1000+2+1022
    sendJump(16'h1000, 3'd7, 10'h200, 4'h0);   // -512 -> 0x1000+2-1024
    sendJump(16'h2222, 3'd7, 10'h000, 4'h0);   // zero offset
    sendJump(16'hFFFE, 3'd7, 10'h000, 4'h0);   // wraps to 0
    sendJump(16'h0000, 3'd7, 10'h3FF, 4'h0);   // -1 word -> 0
    sendJump(16'hFFFE, 3'd1, 10'h010, 4'h0);   // not taken, fall-through wraps
    sendJump(16'hFF00, 3'd7, 10'h1FF, 4'h0);   // forward wrap
    idle(1);
    sendJump(16'h0300, 3'd5, 10'h3F0, 4'b0011); // N=V=1 -> taken
    idle(3);
    sendJump(16'h0400, 3'd6, 10'h020, 4'b0010); // N=1,V=0 -> taken
    idle(2);

    // R12: hold across idle cycles
    check(sbQ.size() == 0, "R2", "queue drained", sbQ.size(), 0);
    heldPc = nextPc;
    heldTk = taken;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(outValid === 1'b0, "R2", "outValid idle", outValid, 0);
      check(nextPc === heldPc && taken === heldTk, "R12", "held nextPc", nextPc, heldPc);
    end
    check(pushed == popped, "R2", "results per request", popped, pushed);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule